// File: doc/BRIEF.md
# Disk Controller Host Register File

This block is the host side of a simple fixed-geometry hard disk controller. A host reaches it over an 8-bit port bus. One chip select covers eight controller registers picked by a 3-bit offset. A second chip select covers two auxiliary ports, picked by the offset LSB: a read-only drive write-protect summary and a control port. The block holds the task-file registers, builds the status and error bytes, runs the command sequencing for sector reads and writes, and streams a 256-byte sector buffer through the data port under a data-request (DRQ) handshake.

The media side is not modelled. A single `mediaDone` strobe stands in for it: it marks that a sector has been fetched (on reads) or committed (on writes). Geometry is fixed at 256-byte sectors and 32 sectors per track. The buffer keeps its contents between commands, so data written by one write command is what the next read command streams back.

Top module: `diskRegFile`

## Requirements
- R1: After reset, or on a control-port write with bit 4 set, busy, DRQ and the error register read 0, and sector count, sector number, cylinder low/high and size/drive/head read 0. This holds even when a command is in progress.
- R2: Controller offsets 2, 3, 4, 5 and 6 read back the last value written as sector count, sector number, cylinder low, cylinder high and size/drive/head. Writes to these offsets are ignored while busy.
- R3: A read at offset 1 returns the error register. A write at offset 1 loads the precompensation register, and `precompStart` equals that value times 4.
- R4: The status byte at offset 7, from bit 7 down to bit 0, is: busy, ready, write error (always 0), seek complete, DRQ, corrected (always 0), command in progress (equal to busy), and error (OR of the error register).
- R5: A command whose upper nibble is 2 (read) with sector number below 32 sets busy and waits for `mediaDone`. It then raises DRQ and returns buffer bytes 0..255 in order, one per data-port read. Busy and DRQ both clear after the 256th read.
- R6: A command with upper nibble 3 (write) to an unprotected drive with sector number below 32 raises busy and DRQ at once. Each data-port write stores the next buffer byte starting at 0. After the 256th byte DRQ clears and busy stays set until `mediaDone`.
- R7: A write command to a drive d whose `wpIn[d]` is set, where d is size/drive/head bits 4:3, sets error bit 2 (aborted) and status bit 0. It raises neither DRQ nor busy.
- R8: A read or write command with sector number 32 or above sets error bit 4 (ID not found) and status bit 0, and stays idle. Sector number 31 is accepted.
- R9: With command bit 2 (multi-sector) set, sector count decrements by one after each sector. The command continues while the count before the decrement was above 1. Without bit 2, sector count is unchanged.
- R10: The auxiliary read at LSB 0 returns `wpIn[d]` on bit 7-d for d = 0..3, the OR of `wpIn` on bit 1, the interrupt request on bit 0, and 0 on bits 3:2.
- R11: A control-port write (auxiliary LSB 1) stores bit 3 (device enable) and bit 2 (wait enable), which read back at the same positions; bit 4 reads as 0. The status ready bit equals device enable.
- R12: Data-port accesses while DRQ is low are ignored: writes leave the buffer unchanged and reads return 0.
- R13: Command writes are ignored while busy. Upper nibbles 1 (restore) and 7 (seek) set seek complete and clear errors. Nibbles 4, 5 and 6 complete at once without error. Any other nibble sets the aborted bit.
- R14: The interrupt request sets when a command finishes, including aborted and immediate commands. A status read or soft reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csMain | input | 1 | Selects the eight controller registers |
| csAux | input | 1 | Selects the auxiliary ports (write protect / control) |
| addr | input | 3 | Register offset |
| wrStb | input | 1 | One-cycle write strobe |
| rdStb | input | 1 | One-cycle read strobe (advances the buffer pointer on data reads) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from the selected register |
| wpIn | input | 4 | Per-drive write-protect switches |
| mediaDone | input | 1 | Media-side sector-complete strobe |
| precompStart | output | 10 | First precompensated cylinder |

## Verification
Every register update, pointer advance and state change happens on the clock edge that samples the strobe. Read data is combinational from the current state. The result of any write, command or `mediaDone` pulse is therefore visible one edge after the strobe, and a data-port read returns the byte at the pointer during the same cycle it is strobed. The bench drives every strobe just after a falling edge and samples `rdData` 5 ns later, within that same low-phase cycle. Status checks are ordinary reads issued after the edge that changed the state. Assertions in the checker cover the one-cycle consequences: a soft reset clearing state, a protected write aborting, the count decrementing, and the interrupt accompanying the end of busy.

// File: rtl/diskRegPkg.sv
package diskRegPkg;
  localparam int DRIVE_CNT = 4;
  localparam int ERR_IDNF_BIT = 4;
  localparam int ERR_ABORT_BIT = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_XFER,
    ST_WR_XFER,
    ST_WR_WAIT
  } xferStateT;

  typedef struct packed {
    logic bufWr;      // store wrData at the buffer pointer
    logic secCntDec;  // one sector of a multi-sector command finished
  } ctrlStrobeT;
endpackage

// File: rtl/diskRegCtrl.sv
module diskRegCtrl
  import diskRegPkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int SECT_PER_TRK = 32,
  localparam int PTR_W = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             cmdWr,
  input  logic [7:0]       cmdByte,
  input  logic             dataRd,
  input  logic             dataWr,
  input  logic             statusRd,
  input  logic             mediaDone,
  input  logic [DRIVE_CNT-1:0] wpIn,
  input  logic [1:0]       driveSel,
  input  logic [7:0]       secNum,
  input  logic [7:0]       secCnt,
  output ctrlStrobeT       stb,
  output logic [PTR_W-1:0] bufPtr,
  output logic             busy,
  output logic             drq,
  output logic             seekDone,
  output logic             irq,
  output logic [7:0]       errReg
);
  xferStateT state;
  logic multi;
  logic xferAcc, lastByte, moreSectors, badSector;

  assign busy = (state != ST_IDLE);
  assign drq = (state == ST_RD_XFER) || (state == ST_WR_XFER);
  assign xferAcc = ((state == ST_RD_XFER) && dataRd) || ((state == ST_WR_XFER) && dataWr);
  assign lastByte = xferAcc && (bufPtr == PTR_W'(BUF_DEPTH - 1));
  assign moreSectors = multi && (secCnt > 8'd1);
  assign badSector = (secNum >= 8'(SECT_PER_TRK));

  always_comb begin
    stb.bufWr = (state == ST_WR_XFER) && dataWr;
    stb.secCntDec = multi && (((state == ST_RD_XFER) && lastByte) ||
                              ((state == ST_WR_WAIT) && mediaDone));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bufPtr <= '0;
      multi <= 1'b0;
      seekDone <= 1'b0;
      irq <= 1'b0;
      errReg <= '0;
    end else if (softRst) begin
      state <= ST_IDLE;
      bufPtr <= '0;
      multi <= 1'b0;
      seekDone <= 1'b0;
      irq <= 1'b0;
      errReg <= '0;
    end else begin
      if (statusRd) irq <= 1'b0;
      if (xferAcc) bufPtr <= bufPtr + 1'b1;
      case (state)
        ST_IDLE: if (cmdWr) begin
          errReg <= '0;
          irq <= 1'b0;
          multi <= cmdByte[2];
          case (cmdByte[7:4])
            4'h1, 4'h7: begin
              seekDone <= 1'b1;
              irq <= 1'b1;
            end
            4'h2: begin
              if (badSector) begin
                errReg[ERR_IDNF_BIT] <= 1'b1;
                irq <= 1'b1;
              end else state <= ST_RD_WAIT;
            end
            4'h3: begin
              if (wpIn[driveSel]) begin
                errReg[ERR_ABORT_BIT] <= 1'b1;
                irq <= 1'b1;
              end else if (badSector) begin
                errReg[ERR_IDNF_BIT] <= 1'b1;
                irq <= 1'b1;
              end else begin
                state <= ST_WR_XFER;
                bufPtr <= '0;
              end
            end
            4'h4, 4'h5, 4'h6: irq <= 1'b1;
            default: begin
              errReg[ERR_ABORT_BIT] <= 1'b1;
              irq <= 1'b1;
            end
          endcase
        end
        ST_RD_WAIT: if (mediaDone) begin
          state <= ST_RD_XFER;
          bufPtr <= '0;
        end
        ST_RD_XFER: if (lastByte) begin
          if (moreSectors) state <= ST_RD_WAIT;
          else begin
            state <= ST_IDLE;
            irq <= 1'b1;
          end
        end
        ST_WR_XFER: if (lastByte) state <= ST_WR_WAIT;
        ST_WR_WAIT: if (mediaDone) begin
          if (moreSectors) begin
            state <= ST_WR_XFER;
            bufPtr <= '0;
          end else begin
            state <= ST_IDLE;
            irq <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/diskRegData.sv
module diskRegData
  import diskRegPkg::*;
#(
  parameter int BUF_DEPTH = 256,
  localparam int PTR_W = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csMain,
  input  logic             csAux,
  input  logic [2:0]       addr,
  input  logic             wrStb,
  input  logic             rdStb,
  input  logic [7:0]       wrData,
  input  logic [DRIVE_CNT-1:0] wpIn,
  input  ctrlStrobeT       stb,
  input  logic [PTR_W-1:0] bufPtr,
  input  logic             busy,
  input  logic             drq,
  input  logic             seekDone,
  input  logic             irq,
  input  logic [7:0]       errReg,
  output logic [7:0]       rdData,
  output logic             softRst,
  output logic             cmdWr,
  output logic             dataRd,
  output logic             dataWr,
  output logic             statusRd,
  output logic [7:0]       secCnt,
  output logic [7:0]       secNum,
  output logic [1:0]       driveSel,
  output logic [9:0]       precompStart
);
  logic [7:0] cylLo, cylHi, sdh, precomp;
  logic devEn, waitEn;
  logic [7:0] sectBuf [BUF_DEPTH];
  logic mainWr, mainRd, ctrlWr;
  logic [7:0] statusByte, wpByte, ctrlByte;

  assign mainWr = csMain && wrStb;
  assign mainRd = csMain && rdStb;
  assign cmdWr = mainWr && (addr == 3'd7);
  assign dataWr = mainWr && (addr == 3'd0);
  assign dataRd = mainRd && (addr == 3'd0);
  assign statusRd = mainRd && (addr == 3'd7);
  assign ctrlWr = csAux && wrStb && addr[0];
  assign softRst = ctrlWr && wrData[4];
  assign driveSel = sdh[4:3];
  assign precompStart = {precomp, 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {secCnt, secNum, cylLo, cylHi, sdh, precomp} <= '0;
      devEn <= 1'b0;
      waitEn <= 1'b0;
    end else begin
      if (ctrlWr) begin
        devEn <= wrData[3];
        waitEn <= wrData[2];
      end
      if (softRst) begin
        {secCnt, secNum, cylLo, cylHi, sdh} <= '0;
      end else begin
        if (stb.secCntDec) secCnt <= secCnt - 8'd1;
        if (mainWr && !busy) begin
          case (addr)
            3'd1: precomp <= wrData;
            3'd2: secCnt <= wrData;
            3'd3: secNum <= wrData;
            3'd4: cylLo <= wrData;
            3'd5: cylHi <= wrData;
            3'd6: sdh <= wrData;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.bufWr) sectBuf[bufPtr] <= wrData;
  end

  always_comb begin
    statusByte = {busy, devEn, 1'b0, seekDone, drq, 1'b0, busy, |errReg};
    ctrlByte = {3'b000, 1'b0, devEn, waitEn, 2'b00};
    wpByte = {4'b0000, 2'b00, |wpIn, irq};
    for (int d = 0; d < DRIVE_CNT; d++) wpByte[7-d] = wpIn[d];
  end

  always_comb begin
    rdData = 8'h00;
    if (csMain) begin
      case (addr)
        3'd0: rdData = drq ? sectBuf[bufPtr] : 8'h00;
        3'd1: rdData = errReg;
        3'd2: rdData = secCnt;
        3'd3: rdData = secNum;
        3'd4: rdData = cylLo;
        3'd5: rdData = cylHi;
        3'd6: rdData = sdh;
        default: rdData = statusByte;
      endcase
    end else if (csAux) begin
      rdData = addr[0] ? ctrlByte : wpByte;
    end
  end
endmodule

// File: rtl/diskRegFile.sv
module diskRegFile
  import diskRegPkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int SECT_PER_TRK = 32,
  localparam int PTR_W = $clog2(BUF_DEPTH)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csMain,
  input  logic       csAux,
  input  logic [2:0] addr,
  input  logic       wrStb,
  input  logic       rdStb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [3:0] wpIn,
  input  logic       mediaDone,
  output logic [9:0] precompStart
);
  ctrlStrobeT stb;
  logic [PTR_W-1:0] bufPtr;
  logic busyW, drqW, seekDoneW, irqW, softRstW, cmdWrW, dataRdW, dataWrW, statusRdW;
  logic [7:0] errW, secCntW, secNumW;
  logic [1:0] driveSelW;

  diskRegCtrl #(.BUF_DEPTH(BUF_DEPTH), .SECT_PER_TRK(SECT_PER_TRK)) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRstW), .cmdWr(cmdWrW), .cmdByte(wrData),
    .dataRd(dataRdW), .dataWr(dataWrW), .statusRd(statusRdW), .mediaDone(mediaDone),
    .wpIn(wpIn), .driveSel(driveSelW), .secNum(secNumW), .secCnt(secCntW),
    .stb(stb), .bufPtr(bufPtr), .busy(busyW), .drq(drqW), .seekDone(seekDoneW),
    .irq(irqW), .errReg(errW)
  );

  diskRegData #(.BUF_DEPTH(BUF_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .csMain(csMain), .csAux(csAux), .addr(addr),
    .wrStb(wrStb), .rdStb(rdStb), .wrData(wrData), .wpIn(wpIn), .stb(stb),
    .bufPtr(bufPtr), .busy(busyW), .drq(drqW), .seekDone(seekDoneW), .irq(irqW),
    .errReg(errW), .rdData(rdData), .softRst(softRstW), .cmdWr(cmdWrW),
    .dataRd(dataRdW), .dataWr(dataWrW), .statusRd(statusRdW), .secCnt(secCntW),
    .secNum(secNumW), .driveSel(driveSelW), .precompStart(precompStart)
  );
endmodule

// File: rtl/diskRegChecker.sv
module diskRegChecker (
  input logic       clk,
  input logic       rstN,
  input logic       csMain,
  input logic       csAux,
  input logic       wrStb,
  input logic [2:0] addr,
  input logic [7:0] wrData,
  input logic [3:0] wpIn,
  input logic [1:0] driveSel,
  input logic       busy,
  input logic       drq,
  input logic       irq,
  input logic       softRst,
  input logic       secCntDec,
  input logic [7:0] secCnt,
  input logic [7:0] errReg
);
  // R5 / R6: a data request only exists inside a running command
  assert_drq_inside_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    drq |-> busy);

  // R1: soft reset leaves an idle, error-free, zeroed task file
  assert_soft_reset_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!busy && !drq && errReg == 8'h00 && secCnt == 8'h00));

  // R7: write command to a protected drive aborts without a transfer
  assert_protected_abort_R7: assert property (@(posedge clk) disable iff (!rstN)
    (csMain && !csAux && wrStb && addr == 3'd7 && wrData[7:4] == 4'h3 && !busy && wpIn[driveSel])
    |=> (errReg[2] && !drq && !busy));

  // R9: each finished sector of a multi-sector command lowers the count by one
  assert_count_decrements_R9: assert property (@(posedge clk) disable iff (!rstN)
    (secCntDec && !softRst) |=> (secCnt == $past(secCnt) - 8'd1));

  // R14: a command that ends by itself raises the interrupt request
  assert_irq_at_end_R14: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(softRst)) |-> irq);
endmodule

bind diskRegFile diskRegChecker u_diskRegChecker (
  .clk(clk), .rstN(rstN), .csMain(csMain), .csAux(csAux), .wrStb(wrStb),
  .addr(addr), .wrData(wrData), .wpIn(wpIn), .driveSel(driveSelW), .busy(busyW),
  .drq(drqW), .irq(irqW), .softRst(softRstW), .secCntDec(stb.secCntDec),
  .secCnt(secCntW), .errReg(errW)
);

// File: tb/test_diskRegFile.sv
module test_diskRegFile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csMain = 1'b0, csAux = 1'b0, wrStb = 1'b0, rdStb = 1'b0, mediaDone = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] wpIn = 4'b0101;
  logic [7:0] rdData;
  logic [9:0] precompStart;

  int nChecks = 0;
  int nErrors = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  diskRegFile i_diskRegFile (
    .clk(clk), .rstN(rstN), .csMain(csMain), .csAux(csAux), .addr(addr),
    .wrStb(wrStb), .rdStb(rdStb), .wrData(wrData), .rdData(rdData),
    .wpIn(wpIn), .mediaDone(mediaDone), .precompStart(precompStart)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each strobed read mid-cycle against the queued item
  initial forever begin
    @(negedge clk);
    #5;
    if (rdStb && expQ.size() > 0) check(tagQ.pop_front(), rdData, expQ.pop_front());
  end

  task automatic busWr(input bit aux, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    csMain = !aux; csAux = aux; addr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    csMain = 1'b0; csAux = 1'b0; wrStb = 1'b0;
  endtask

  task automatic busRd(input bit aux, input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    csMain = !aux; csAux = aux; addr = a; rdStb = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    csMain = 1'b0; csAux = 1'b0; rdStb = 1'b0;
  endtask

  task automatic pulseMedia();
    @(negedge clk);
    mediaDone = 1'b1;
    @(negedge clk);
    mediaDone = 1'b0;
  endtask

  task automatic finishRun();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    busRd(0, 7, 8'h00, "R1 status after reset");
    busRd(0, 1, 8'h00, "R1 error after reset");
    busRd(0, 2, 8'h00, "R1 sector count after reset");
    // control port and ready bit
    busWr(1, 1, 8'h0C);
    busRd(1, 1, 8'h0C, "R11 control readback");
    busRd(0, 7, 8'h40, "R4 R11 status ready only");
    // write-protect port: drives 0 and 2 protected
    busRd(1, 0, 8'hA2, "R10 write-protect layout");
    // task file
    busWr(0, 2, 8'h03); busWr(0, 3, 8'h05); busWr(0, 4, 8'h34);
    busWr(0, 5, 8'h02); busWr(0, 6, 8'h0B);
    busRd(0, 2, 8'h03, "R2 sector count");
    busRd(0, 3, 8'h05, "R2 sector number");
    busRd(0, 4, 8'h34, "R2 cylinder low");
    busRd(0, 5, 8'h02, "R2 cylinder high");
    busRd(0, 6, 8'h0B, "R2 size/drive/head");
    busWr(0, 1, 8'h11);
    check("R3 precompensation start", precompStart, 10'h044);
    busRd(0, 1, 8'h00, "R3 offset 1 reads error");
    // data port without DRQ
    busWr(0, 0, 8'h77);
    busRd(0, 0, 8'h00, "R12 data read without DRQ");
    // single write to drive 1
    busWr(0, 7, 8'h30);
    busRd(0, 7, 8'hCA, "R6 write DRQ at once");
    for (int i = 0; i < 256; i++) busWr(0, 0, 8'(i) ^ 8'h5A);
    busRd(0, 7, 8'hC2, "R6 busy awaiting media");
    pulseMedia();
    busRd(1, 0, 8'hA3, "R14 irq after write");
    busRd(0, 7, 8'h40, "R6 idle after media");
    busRd(1, 0, 8'hA2, "R14 irq cleared by status read");
    busRd(0, 2, 8'h03, "R9 count unchanged without multi");
    // ignored data write, then read back
    busWr(0, 0, 8'hEE);
    busWr(0, 7, 8'h20);
    busRd(0, 7, 8'hC2, "R5 read waits for media");
    pulseMedia();
    busRd(0, 7, 8'hCA, "R5 DRQ after media");
    busRd(0, 0, 8'h5A, "R5 R12 byte 0 kept");
    for (int i = 1; i < 256; i++) busRd(0, 0, 8'(i) ^ 8'h5A, "R5 sector byte");
    busRd(0, 7, 8'h40, "R5 idle after 256th byte");
    // multi-sector write of two sectors
    busWr(0, 2, 8'h02);
    busWr(0, 7, 8'h34);
    for (int i = 0; i < 256; i++) busWr(0, 0, 8'(i));
    pulseMedia();
    busRd(0, 2, 8'h01, "R9 count after first sector");
    busRd(0, 7, 8'hCA, "R9 second sector DRQ");
    for (int i = 0; i < 256; i++) busWr(0, 0, 8'(i));
    pulseMedia();
    busRd(0, 2, 8'h00, "R9 count after last sector");
    busRd(0, 7, 8'h40, "R9 idle after multi");
    // protected drive 2
    busWr(0, 6, 8'h10);
    busWr(0, 7, 8'h30);
    busRd(0, 7, 8'h41, "R7 status after protected write");
    busRd(0, 1, 8'h04, "R7 aborted bit");
    // sector number boundary on drive 1
    busWr(0, 6, 8'h08);
    busWr(0, 3, 8'h20);
    busWr(0, 7, 8'h20);
    busRd(0, 7, 8'h41, "R8 status sector 32");
    busRd(0, 1, 8'h10, "R8 ID not found bit");
    busWr(0, 3, 8'h1F);
    busWr(0, 7, 8'h20);
    busRd(0, 7, 8'hC2, "R8 sector 31 accepted");
    // while busy: task-file write and command ignored
    busWr(0, 2, 8'h99);
    busRd(0, 2, 8'h00, "R2 write ignored while busy");
    busWr(0, 7, 8'h70);
    busRd(0, 7, 8'hC2, "R13 command ignored while busy");
    // soft reset in mid-command
    busWr(1, 1, 8'h1C);
    busRd(0, 7, 8'h40, "R1 status after soft reset");
    busRd(0, 3, 8'h00, "R1 sector number after soft reset");
    busRd(0, 6, 8'h00, "R1 size/drive/head after soft reset");
    busRd(1, 1, 8'h0C, "R11 reset bit reads zero");
    // command classes
    busWr(0, 7, 8'h90);
    busRd(0, 7, 8'h41, "R13 unknown class status");
    busRd(0, 1, 8'h04, "R13 unknown class aborts");
    busWr(0, 7, 8'h70);
    busRd(0, 7, 8'h50, "R13 seek sets seek complete");
    busRd(0, 1, 8'h00, "R13 seek clears errors");
    finishRun();
  end
endmodule